// File: doc/BRIEF.md
# Clock-Synchronous Serial Port

This block moves one byte at a time over a three-wire synchronous link: a serial data output, a serial data input and a bit clock. A receive-ready strobe tells the far end when a new byte has been loaded. Software loads the byte to send through a bus write strobe and reads the received byte back from the same register. A small mode word picks where the bit clock comes from, the order in which bits travel, and the speed of the clock made inside the block.

With the internal clock, writing the data register starts a transfer. The block drives a bit clock with exactly eight pulses and then parks it high. It raises an interrupt request and releases the data output to high impedance. With an external clock, the peer drives the bit clock. The block synchronises that clock to its own, counts eight rising edges and raises the request. It keeps shifting on any further edges. Its counter is armed only by a write made while the external clock is high.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, srdy_o and sclk_o are high, sout_oe_o and irq_o are low, and rdata_o is zero.
- R2: A data write loads rdata_o with the written byte. srdy_o is high during the write cycle and low from the cycle after it until the first falling edge of the bit clock.
- R3: The mode word is written through wdata_i bits [2:0]. Bit 2 selects the internal clock speed: 0 divides the system clock by DIV_FAST (default 8) and 1 divides it by DIV_SLOW (default 32). After a write in internal mode the bit clock first stays high for one half period, and every later half period also lasts exactly half the division in system clocks.
- R4: At each falling edge of the bit clock the next bit is driven on sout_o, with sout_oe_o high. Mode bit 1 = 0 sends the LSB first and 1 sends the MSB first. srdy_o returns high at the first falling edge.
- R5: At each rising edge of the bit clock sin_i is sampled and the register shifts one place. After eight bits rdata_o holds the received byte, taken in the same order as bits are sent.
- R6: In internal mode (mode bit 0 = 0) a transfer has exactly eight clock pulses. The clock then stays high, irq_o goes high and sout_oe_o goes low.
- R7: irq_o stays high until an irq_clr_i pulse clears it.
- R8: In external mode (mode bit 0 = 1), sclk_oe_o is low and sclk_i is taken through a synchroniser. irq_o stays low after seven rising edges and goes high after the eighth.
- R9: In external mode, rising edges after the eighth keep shifting sin_i into the register and keep driving new bits on sout_o, and irq_o stays high.
- R10: In external mode, a data write made while sclk_i is low loads the register but does not arm the counter, so eight later clocks leave irq_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr_i | input | 1 | Write strobe for the data register |
| mode_wr_i | input | 1 | Write strobe for the mode word |
| irq_clr_i | input | 1 | Clears the interrupt request |
| wdata_i | input | DATA_W | Write data (mode uses bits [2:0]) |
| rdata_o | output | DATA_W | Data register contents |
| irq_o | output | 1 | Interrupt request flag |
| sclk_i | input | 1 | External bit clock |
| sclk_o | output | 1 | Internal bit clock |
| sclk_oe_o | output | 1 | Bit clock output enable (internal mode) |
| sin_i | input | 1 | Serial data in |
| sout_o | output | 1 | Serial data out |
| sout_oe_o | output | 1 | Serial data output enable |
| srdy_o | output | 1 | Receive-ready strobe, low while waiting for the first clock |

## Verification
The bench builds the block with its defaults: an 8-bit frame, dividers of 8 and 32, and a two-stage synchroniser. Both clock speeds can therefore be selected at run time through the mode word, and the half-period lengths of 4 and 16 system clocks are each measured edge to edge. The bench acts as the remote device in both clock modes, so it sees both bit orders, external transfers longer than eight clocks, and a counter left unarmed by a write made while the clock is low.

// File: rtl/ssio_pkg.sv
package ssio_pkg;
   localparam int MODE_W = 3;

   typedef struct packed {
      logic div_slow;
      logic msb_first;
      logic ext_clk;
   } ssio_mode_t;

   typedef struct packed {
      logic rise;
      logic fall;
   } ssio_edge_t;
endpackage

// File: rtl/ssio_clk_sync.sv
module ssio_clk_sync
   import ssio_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       async_i,
   output logic       level_o,
   output ssio_edge_t edge_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   initial begin : elab_chk
      assert (STAGES >= 2) else $error("STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         last_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o     = chain_q[STAGES-1];
   assign edge_o.rise = level_o & ~last_q;
   assign edge_o.fall = ~level_o & last_q;
endmodule

// File: rtl/ssio_clkgen.sv
module ssio_clkgen #(
   parameter int DIV_FAST = 8,
   parameter int DIV_SLOW = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic restart_i,
   input  logic slow_i,
   output logic sclk_o,
   output logic fall_o,
   output logic rise_o
);
   localparam int HALF_FAST = DIV_FAST / 2;
   localparam int HALF_SLOW = DIV_SLOW / 2;
   localparam int HALF_MAX  = (HALF_FAST > HALF_SLOW) ? HALF_FAST : HALF_SLOW;
   localparam int CNT_W     = $clog2(HALF_MAX + 1);

   logic [CNT_W-1:0] div_q;
   logic [CNT_W-1:0] half_m1;
   logic             sclk_q;
   logic             terminal;

   initial begin : elab_chk
      assert (DIV_FAST >= 4 && DIV_FAST % 2 == 0) else $error("DIV_FAST must be even and >= 4");
      assert (DIV_SLOW >= 4 && DIV_SLOW % 2 == 0) else $error("DIV_SLOW must be even and >= 4");
   end

   generate
      if (DIV_FAST == DIV_SLOW) begin : g_single
         assign half_m1 = CNT_W'(HALF_FAST - 1);
      end else begin : g_dual
         assign half_m1 = slow_i ? CNT_W'(HALF_SLOW - 1) : CNT_W'(HALF_FAST - 1);
      end
   endgenerate

   assign terminal = run_i && (div_q == half_m1);
   assign fall_o   = terminal && sclk_q;
   assign rise_o   = terminal && !sclk_q;
   assign sclk_o   = sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         sclk_q <= 1'b1;
      end else if (restart_i || !run_i) begin
         div_q  <= '0;
         sclk_q <= 1'b1;
      end else if (terminal) begin
         div_q  <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         div_q  <= div_q + 1'b1;
      end
   end

   AST_CLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> sclk_o) else $error("clock not parked high"); // R6
   AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o || fall_o) |=> ($past(sclk_o) != sclk_o) || $past(restart_i)) else $error("tick without toggle"); // R3
endmodule

// File: rtl/ssio_shifter.sv
module ssio_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_data_i,
   input  logic         shift_i,
   input  logic         msb_first_i,
   input  logic         sin_i,
   output logic [W-1:0] data_o,
   output logic         out_bit_o
);
   logic [W-1:0] q;
   logic [W-1:0] shifted;

   initial begin : elab_chk
      assert (W >= 3) else $error("W must be at least 3");
   end

   assign shifted   = msb_first_i ? {q[W-2:0], sin_i} : {sin_i, q[W-1:1]};
   assign out_bit_o = msb_first_i ? q[W-1] : q[0];
   assign data_o    = q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (load_i)  q <= load_data_i;
      else if (shift_i) q <= shifted;
   end

   AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !load_i && !msb_first_i) |=> (data_o[W-2:0] == $past(data_o[W-1:1]))) else $error("lsb shift"); // R5
   AST_SHIFT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !load_i && msb_first_i) |=> (data_o[W-1:1] == $past(data_o[W-2:0]))) else $error("msb shift"); // R5
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
   import ssio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_FAST    = 8,
   parameter int DIV_SLOW    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr_i,
   input  logic              mode_wr_i,
   input  logic              irq_clr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o,
   input  logic              sclk_i,
   output logic              sclk_o,
   output logic              sclk_oe_o,
   input  logic              sin_i,
   output logic              sout_o,
   output logic              sout_oe_o,
   output logic              srdy_o
);
   localparam int CNT_W = $clog2(DATA_W);

   ssio_mode_t       mode_q;
   ssio_edge_t       ext_edge;
   logic             ext_lvl;
   logic             ext;
   logic             int_sclk, int_fall, int_rise;
   logic             rise_evt, fall_evt;
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic             srdy_q, irq_q, sout_q, oe_q;
   logic             arm, shift_en, last_bit, out_bit;

   initial begin : elab_chk
      assert (DATA_W >= MODE_W) else $error("DATA_W too small for mode word");
   end

   assign ext = mode_q.ext_clk;

   ssio_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(sclk_i),
      .level_o(ext_lvl), .edge_o(ext_edge));

   ssio_clkgen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run_i(busy_q && !ext),
      .restart_i(data_wr_i && !ext), .slow_i(mode_q.div_slow),
      .sclk_o(int_sclk), .fall_o(int_fall), .rise_o(int_rise));

   assign rise_evt = (ext ? ext_edge.rise : int_rise) && !data_wr_i;
   assign fall_evt = (ext ? ext_edge.fall : int_fall) && !data_wr_i;
   assign arm      = data_wr_i && (!ext || ext_lvl);
   assign shift_en = rise_evt && (ext || busy_q);
   assign last_bit = rise_evt && busy_q && (cnt_q == '0);

   ssio_shifter #(.W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_i(data_wr_i), .load_data_i(wdata_i),
      .shift_i(shift_en), .msb_first_i(mode_q.msb_first), .sin_i(sin_i),
      .data_o(rdata_o), .out_bit_o(out_bit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= '0;
      else if (mode_wr_i) mode_q <= ssio_mode_t'(wdata_i[MODE_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (arm) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(DATA_W - 1);
      end else if (rise_evt && busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srdy_q <= 1'b1;
         irq_q  <= 1'b0;
         sout_q <= 1'b1;
         oe_q   <= 1'b0;
      end else begin
         if (data_wr_i)     srdy_q <= 1'b0;
         else if (fall_evt) srdy_q <= 1'b1;

         if (last_bit)       irq_q <= 1'b1;
         else if (irq_clr_i) irq_q <= 1'b0;

         if (fall_evt) begin
            sout_q <= out_bit;
            oe_q   <= 1'b1;
         end else if (last_bit && !ext) begin
            oe_q   <= 1'b0;
         end else if (mode_wr_i && !wdata_i[0] && !busy_q) begin
            oe_q   <= 1'b0;
         end
      end
   end

   assign srdy_o    = srdy_q | data_wr_i;
   assign irq_o     = irq_q;
   assign sout_o    = sout_q;
   assign sout_oe_o = oe_q;
   assign sclk_o    = int_sclk;
   assign sclk_oe_o = ~ext;

   AST_SRDY_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(srdy_o) |-> $past(data_wr_i)) else $error("srdy fell without write"); // R2
   AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (!busy_q || $past(data_wr_i))) else $error("irq during transfer"); // R6
   AST_SOUT_HIZ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext && !busy_q) |-> !sout_oe_o) else $error("sout driven while idle"); // R6
   AST_NO_STRAY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext && !busy_q && !data_wr_i && !mode_wr_i) |=> $stable(rdata_o)) else $error("idle shift"); // R5
endmodule

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
   localparam int DW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic data_wr = 0, mode_wr = 0, irq_clr = 0, sclk_in = 1, sin = 0;
   logic [DW-1:0] wdata = '0, rdata;
   logic irq, sclk_out, sclk_oe, sout, sout_oe, srdy;
   int checks = 0, errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   sync_serial_port dut (
      .clk(clk), .rst_n(rst_n), .data_wr_i(data_wr), .mode_wr_i(mode_wr),
      .irq_clr_i(irq_clr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
      .sclk_i(sclk_in), .sclk_o(sclk_out), .sclk_oe_o(sclk_oe), .sin_i(sin),
      .sout_o(sout), .sout_oe_o(sout_oe), .srdy_o(srdy));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic bit_at(logic [DW-1:0] b, int k, bit msb);
      return msb ? b[DW-1-k] : b[k];
   endfunction

   function automatic logic [DW-1:0] shift_model(logic [DW-1:0] q, logic s, bit msb);
      return msb ? {q[DW-2:0], s} : {s, q[DW-1:1]};
   endfunction

   task automatic write_mode(bit ext, bit msb, bit slow);
      @(negedge clk); mode_wr = 1; wdata = {{(DW-3){1'b0}}, slow, msb, ext};
      @(negedge clk); mode_wr = 0;
   endtask

   task automatic write_data(logic [DW-1:0] b);
      @(negedge clk); data_wr = 1; wdata = b; #1;
      chk("R2 srdy high in write cycle", srdy, 1);
      @(negedge clk); data_wr = 0; #1;
      chk("R2 rdata after write", rdata, b);
   endtask

   task automatic clear_irq();
      @(negedge clk); irq_clr = 1;
      @(negedge clk); irq_clr = 0; #1;
      chk("R7 irq cleared", irq, 0);
   endtask

   task automatic run_int(logic [DW-1:0] tx, logic [DW-1:0] rx, bit msb, bit slow);
      int half, run_len, falls, rises;
      logic prev, stayed, len_ok;
      logic [DW-1:0] cap;
      bit done;
      half = slow ? 16 : 4;
      write_mode(0, msb, slow);
      write_data(tx);
      chk("R2 srdy low after write", srdy, 0);
      chk("R3 clock high after write", sclk_out, 1);
      prev = 1; run_len = 1; falls = 0; rises = 0; cap = '0; done = 0; len_ok = 1;
      for (int cyc = 0; cyc < 600 && !done; cyc++) begin
         @(negedge clk); #1;
         if (sclk_out != prev) begin
            if (run_len != half) len_ok = 0;
            run_len = 1; prev = sclk_out;
            if (!sclk_out) begin
               if (falls == 0) chk("R4 srdy high at first fall", srdy, 1);
               if (sout_oe !== 1'b1) len_ok = 0;
               sin = bit_at(rx, falls, msb);
               falls++;
            end else begin
               if (msb) cap[DW-1-rises] = sout; else cap[rises] = sout;
               rises++;
            end
         end else run_len++;
         if (irq) done = 1;
      end
      chk("R3 half periods and R4 output enable", len_ok, 1);
      chk("R6 falling edges", falls, DW);
      chk("R6 rising edges", rises, DW);
      chk("R4 bits sent", cap, tx);
      chk("R5 byte received", rdata, rx);
      chk("R6 sout released", sout_oe, 0);
      stayed = 1;
      repeat (20) begin @(negedge clk); #1; if (!sclk_out) stayed = 0; end
      chk("R6 clock parked high", stayed, 1);
      chk("R7 irq held", irq, 1);
      clear_irq();
   endtask

   task automatic run_ext(logic [DW-1:0] tx, logic [15:0] rx, int nclk, bit msb, bit arm_high);
      logic [DW-1:0] model;
      sclk_in = 1;
      write_mode(1, msb, 0);
      #1 chk("R8 clock output disabled", sclk_oe, 0);
      if (!arm_high) begin sclk_in = 0; repeat (6) @(negedge clk); end
      write_data(tx);
      model = tx;
      for (int k = 0; k < nclk; k++) begin
         sclk_in = 0;
         repeat (8) @(negedge clk); #1;
         if (arm_high) chk(k < DW ? "R4 ext bit out" : "R9 ext bit out after eighth", sout, bit_at(model, 0, msb));
         sin = rx[k];
         sclk_in = 1;
         model = shift_model(model, rx[k], msb);
         repeat (8) @(negedge clk); #1;
         if (k == DW-2) chk("R8 irq low after seven clocks", irq, 0);
         if (k == DW-1) chk(arm_high ? "R8 irq after eight clocks" : "R10 unarmed irq stays low", irq, arm_high);
      end
      chk(nclk > DW ? "R9 shifting continues" : "R5 ext byte received", rdata, model);
      if (arm_high && nclk > DW) chk("R9 irq stays high", irq, 1);
      if (arm_high) clear_irq();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      repeat (3) @(negedge clk); #1;
      chk("R1 srdy", srdy, 1);
      chk("R1 sclk", sclk_out, 1);
      chk("R1 sout_oe", sout_oe, 0);
      chk("R1 irq", irq, 0);
      chk("R1 rdata", rdata, 0);
      rst_n = 1;
      run_int(8'hA5, 8'h3C, 0, 0);
      run_int(8'h00, 8'hFF, 1, 1);
      run_int(8'hFF, 8'h00, 0, 1);
      for (int i = 0; i < 6; i++)
         run_int(DW'($urandom), DW'($urandom), bit'($urandom % 2), bit'($urandom % 2));
      run_ext(8'h96, 16'hB4E1, 11, 0, 1);
      run_ext(8'h5A, 16'h0F3C, 8, 1, 1);
      run_ext(8'hC3, 16'h1234, 8, 0, 0);
      for (int i = 0; i < 2; i++)
         run_ext(DW'($urandom), 16'($urandom), 8 + int'($urandom % 4), bit'($urandom % 2), 1);
      run_int(8'h81, 8'h7E, 1, 0);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule